// File: doc/BRIEF.md
# Interrupt Event State Coalescer

The block holds a two-bit state for each of a parameterized number of interrupt sources: a pending bit P, set while a notification for the source sits in the event queue or awaits end-of-interrupt, and a queued bit Q, set when the source fires again while P is already set. Hardware trigger pulses advance this state so that a source never has more than one notification outstanding. Notifications leave on a valid/ready channel that carries the source number.

Software reaches the state through a load/store port that addresses one source and picks an operation from the page offset. Every load on the state page reads the prior state and applies its update in the same cycle, so the read and the update cannot be split. Loads can peek at the state, force it to any of its four values, or perform end-of-interrupt. A store at one offset also performs end-of-interrupt. A store on a separate trigger page raises a trigger on the addressed source. When the consumer stalls, granted source numbers wait in a small FIFO. Sources that still need to send wait in per-source request flags that a round-robin arbiter serves.

Top module: `esb_coalescer`

## Requirements
- R1: After reset every source reads state 00, notif_valid_o is low and mm_rvalid_o is low.
- R2: A trigger on a source in state 00 moves it to 10 (P set) and produces exactly one notification carrying that source number.
- R3: A trigger on a source in state 10 or 11 moves it to 11 and produces no notification.
- R4: A trigger on a source in state 01 is dropped: the state stays 01 and no notification is produced.
- R5: A load on the state page (mm_trig_pg_i=0) at offset 0x800 returns the prior state in mm_rdata_o[1:0], with P in bit 1 (value 0x2) and Q in bit 0 (value 0x1) and all upper bits zero. The state is not changed. mm_rvalid_o is high in the cycle after the request. Offset bits [7:0] are ignored for every access.
- R6: Loads on the state page at offsets 0xC00, 0xD00, 0xE00 and 0xF00 force the state to 00, 01, 10 and 11. Each returns the prior state and produces no notification.
- R7: A load on the state page at offset 0x000 performs end-of-interrupt and returns the prior state. If Q was 0 the state becomes 00. If Q was 1 the state becomes 10 and one new notification is produced.
- R8: A store on the state page at offset 0x400 performs the same end-of-interrupt as R7. A store returns no read data (mm_rvalid_o stays low).
- R9: A store on the trigger page (mm_trig_pg_i=1, any offset) acts as a trigger on the addressed source, with the rules of R2 to R4.
- R10: When a load/store access and a hardware trigger hit the same source in one cycle, the access is applied first and the trigger is then evaluated on the resulting state.
- R11: While notif_ready_i is low, notif_valid_o stays high and notif_src_o stays stable. No notification is lost or duplicated, and sources are served in round-robin order.
- R12: Loads at any other state-page offset, and loads on the trigger page, return zero and change nothing. Stores at other state-page offsets change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| trig_i | input | NUM_SRC | Per-source hardware trigger pulses |
| mm_req_i | input | 1 | Access request, one cycle |
| mm_we_i | input | 1 | 1 = store, 0 = load |
| mm_trig_pg_i | input | 1 | 1 = trigger page, 0 = state page |
| mm_src_i | input | SRC_W | Addressed source |
| mm_off_i | input | 12 | Page offset selecting the operation |
| mm_rvalid_o | output | 1 | Load data valid, one cycle after the request |
| mm_rdata_o | output | 64 | Load data: prior state in bits [1:0] |
| notif_valid_o | output | 1 | Notification available |
| notif_ready_i | input | 1 | Consumer accepts the notification |
| notif_src_o | output | SRC_W | Source number of the notification |

## Verification
A hardware trigger and a load/store access can land on the same source in the same clock. The random phase provokes this by often pairing the access with a trigger bit on the addressed source. Directed steps do the same for force-to-01, force-to-00 and end-of-interrupt on state 11. A reference model in the bench applies the access first and then the trigger. The outcome is judged by the prior state the next load returns, and by comparing per-source notification counts after the channel has drained.

// File: rtl/esb_pkg.sv
package esb_pkg;
  typedef enum logic [2:0] {OP_NONE, OP_GET, OP_EOI, OP_SET, OP_TRIG} esb_op_e;

  // page-offset nibble [11:8] that selects the operation
  localparam logic [3:0] NIB_LD_EOI = 4'h0;
  localparam logic [3:0] NIB_ST_EOI = 4'h4;
  localparam logic [3:0] NIB_GET    = 4'h8;

  function automatic esb_op_e esb_decode(input logic we, input logic trig_pg,
                                         input logic [3:0] nib);
    esb_op_e op;
    op = OP_NONE;
    if (trig_pg) begin
      if (we) op = OP_TRIG;
    end else if (!we) begin
      if (nib == NIB_LD_EOI)      op = OP_EOI;
      else if (nib == NIB_GET)    op = OP_GET;
      else if (nib[3:2] == 2'b11) op = OP_SET;
    end else if (nib == NIB_ST_EOI) begin
      op = OP_EOI;
    end
    return op;
  endfunction
endpackage

// File: rtl/esb_cell.sv
module esb_cell
  import esb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       mm_hit_i,
  input  esb_op_e    op_i,
  input  logic [1:0] set_val_i,
  input  logic       trig_i,
  output logic [1:0] pq_o,
  output logic       emit_o
);
  logic [1:0] pq_q, pq_mm, pq_d;

  always_comb begin
    pq_mm  = pq_q;
    emit_o = 1'b0;
    if (mm_hit_i) begin
      case (op_i)
        OP_EOI: begin
          if (pq_q[0]) begin
            pq_mm  = 2'b10;
            emit_o = 1'b1;
          end else begin
            pq_mm = 2'b00;
          end
        end
        OP_SET:  pq_mm = set_val_i;
        default: ;
      endcase
    end
    // trigger sees the state left by the access
    pq_d = pq_mm;
    if (trig_i) begin
      case (pq_mm)
        2'b00: begin
          pq_d   = 2'b10;
          emit_o = 1'b1;
        end
        2'b01:   pq_d = 2'b01;
        default: pq_d = 2'b11;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) pq_q <= 2'b00;
    else         pq_q <= pq_d;
  end

  assign pq_o = pq_q;

  // R4
  masked_drop_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pq_q == 2'b01 && trig_i && !mm_hit_i) |=> (pq_q == 2'b01));

  // R3
  pending_merge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pq_q[1] && trig_i && !mm_hit_i) |=> (pq_q == 2'b11));
endmodule

// File: rtl/esb_rr_arb.sv
module esb_rr_arb #(
  parameter int unsigned N     = 8,
  parameter int unsigned IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N-1:0]     req_i,
  input  logic             en_i,
  output logic [N-1:0]     gnt_o,
  output logic [IDX_W-1:0] gnt_idx_o
);
  logic [IDX_W-1:0] ptr_q;
  logic             found;

  always_comb begin
    gnt_o     = '0;
    gnt_idx_o = '0;
    found     = 1'b0;
    for (int unsigned k = 0; k < N; k++) begin
      int unsigned idx;
      idx = (int'(ptr_q) + k) % N;
      if (!found && en_i && req_i[idx]) begin
        found      = 1'b1;
        gnt_o[idx] = 1'b1;
        gnt_idx_o  = IDX_W'(idx);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (found)
      ptr_q <= (int'(gnt_idx_o) == N - 1) ? '0 : gnt_idx_o + 1'b1;
  end

  // R11
  one_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt_o));

  // R11
  grant_has_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((gnt_o & ~req_i) == '0));
endmodule

// File: rtl/esb_fifo.sv
module esb_fifo #(
  parameter int unsigned WIDTH = 3,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [WIDTH-1:0] data_i,
  input  logic             pop_i,
  output logic [WIDTH-1:0] data_o,
  output logic             empty_o,
  output logic             full_o
);
  logic [DEPTH-1:0][WIDTH-1:0] mem_q;
  logic [AW-1:0]               rd_q, wr_q;
  logic [AW:0]                 cnt_q;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == (AW+1)'(DEPTH));
  assign data_o  = mem_q[rd_q];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mem_q <= '0;
      rd_q  <= '0;
      wr_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push_i) begin
        mem_q[wr_q] <= data_i;
        wr_q <= (int'(wr_q) == DEPTH - 1) ? '0 : wr_q + 1'b1;
      end
      if (pop_i)
        rd_q <= (int'(rd_q) == DEPTH - 1) ? '0 : rd_q + 1'b1;
      cnt_q <= cnt_q + (AW+1)'(push_i) - (AW+1)'(pop_i);
    end
  end

  // R11
  no_overflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> !full_o);

  // R11
  no_underflow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> !empty_o);
endmodule

// File: rtl/esb_coalescer.sv
module esb_coalescer
  import esb_pkg::*;
#(
  parameter int unsigned NUM_SRC    = 8,
  parameter int unsigned FIFO_DEPTH = 4,
  localparam int unsigned SRC_W     = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic               mm_req_i,
  input  logic               mm_we_i,
  input  logic               mm_trig_pg_i,
  input  logic [SRC_W-1:0]   mm_src_i,
  input  logic [11:0]        mm_off_i,
  output logic               mm_rvalid_o,
  output logic [63:0]        mm_rdata_o,
  output logic               notif_valid_o,
  input  logic               notif_ready_i,
  output logic [SRC_W-1:0]   notif_src_o
);
  esb_op_e                  op;
  logic [NUM_SRC-1:0]       mm_hit, trig_eff, emit, gnt;
  logic [NUM_SRC-1:0][1:0]  pq;
  logic [NUM_SRC-1:0]       req_q;
  logic [SRC_W-1:0]         gnt_idx;
  logic                     fifo_full, fifo_empty, push, pop;
  logic [1:0]               sel_pq;

  assign op = esb_decode(mm_we_i, mm_trig_pg_i, mm_off_i[11:8]);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    assign mm_hit[s]   = mm_req_i && (int'(mm_src_i) == s);
    assign trig_eff[s] = trig_i[s] | (mm_hit[s] && op == OP_TRIG);

    esb_cell i_cell (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .mm_hit_i  (mm_hit[s]),
      .op_i      (op),
      .set_val_i (mm_off_i[9:8]),
      .trig_i    (trig_eff[s]),
      .pq_o      (pq[s]),
      .emit_o    (emit[s])
    );
  end

  always_comb begin
    sel_pq = 2'b00;
    for (int s = 0; s < NUM_SRC; s++)
      if (mm_hit[s]) sel_pq = pq[s];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mm_rvalid_o <= 1'b0;
      mm_rdata_o  <= '0;
    end else begin
      mm_rvalid_o <= mm_req_i && !mm_we_i;
      if (mm_req_i && !mm_we_i)
        mm_rdata_o <= (op == OP_GET || op == OP_EOI || op == OP_SET)
                      ? {62'd0, sel_pq} : 64'd0;
    end
  end

  // flags hold sources that owe a notification until the FIFO takes them
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) req_q <= '0;
    else         req_q <= (req_q & ~gnt) | emit;
  end

  esb_rr_arb #(.N(NUM_SRC), .IDX_W(SRC_W)) i_arb (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .req_i     (req_q),
    .en_i      (!fifo_full),
    .gnt_o     (gnt),
    .gnt_idx_o (gnt_idx)
  );

  assign push = |gnt;
  assign pop  = notif_valid_o && notif_ready_i;

  esb_fifo #(.WIDTH(SRC_W), .DEPTH(FIFO_DEPTH)) i_fifo (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .push_i  (push),
    .data_i  (gnt_idx),
    .pop_i   (pop),
    .data_o  (notif_src_o),
    .empty_o (fifo_empty),
    .full_o  (fifo_full)
  );

  assign notif_valid_o = !fifo_empty;

  // R11
  hold_notif_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (notif_valid_o && !notif_ready_i) |=> (notif_valid_o && $stable(notif_src_o)));

  // R5
  load_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mm_req_i && !mm_we_i) |=> mm_rvalid_o);

  // R8
  store_no_resp_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mm_req_i && !mm_we_i) |=> !mm_rvalid_o);

  // R5
  rdata_upper_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mm_rvalid_o |-> (mm_rdata_o[63:2] == '0));
endmodule

// File: tb/test_esb_coalescer.sv
module test_esb_coalescer;
  localparam int N  = 8;
  localparam int SW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [N-1:0]  trig = '0;
  logic          mm_req = 1'b0, mm_we = 1'b0, mm_pg = 1'b0;
  logic [SW-1:0] mm_src = '0;
  logic [11:0]   mm_off = '0;
  logic          rvalid;
  logic [63:0]   rdata;
  logic          nvalid;
  logic          nready = 1'b0;
  logic [SW-1:0] nsrc;

  int total = 0, bad = 0;
  int cyc = 0;
  bit hold = 1'b0, drain = 1'b0;
  logic [1:0] pq_m [N];
  int exp_cnt [N];
  int got_cnt [N];

  always #2.5 clk = ~clk;

  esb_coalescer #(.NUM_SRC(N), .FIFO_DEPTH(4)) i_esb_coalescer (
    .clk_i(clk), .rst_ni(rst_n), .trig_i(trig),
    .mm_req_i(mm_req), .mm_we_i(mm_we), .mm_trig_pg_i(mm_pg),
    .mm_src_i(mm_src), .mm_off_i(mm_off),
    .mm_rvalid_o(rvalid), .mm_rdata_o(rdata),
    .notif_valid_o(nvalid), .notif_ready_i(nready), .notif_src_o(nsrc)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // reference: the access first, then the trigger
  function automatic void model(input int s, input bit mm, input bit we, input bit pg,
                                input logic [11:0] off, input bit trg, input bit commit,
                                output bit emit, output logic [63:0] rd, output bit rv);
    logic [1:0] pq;
    bit t;
    pq = pq_m[s]; emit = 0; rd = '0; rv = 0; t = trg;
    if (mm) begin
      if (pg) begin
        if (we) t = 1; else rv = 1;
      end else if (!we) begin
        rv = 1;
        case (off[11:8])
          4'h0: begin rd = {62'd0, pq}; pq = pq[0] ? 2'b10 : 2'b00; emit = pq[1]; end
          4'h8: rd = {62'd0, pq};
          4'hC, 4'hD, 4'hE, 4'hF: begin rd = {62'd0, pq}; pq = off[9:8]; end
          default: ;
        endcase
      end else if (off[11:8] == 4'h4) begin
        pq = pq[0] ? 2'b10 : 2'b00; emit = pq[1];
      end
    end
    if (t) begin
      if (pq == 2'b00) begin pq = 2'b10; emit = 1; end
      else if (pq != 2'b01) pq = 2'b11;
    end
    if (commit) begin
      pq_m[s] = pq;
      if (emit) exp_cnt[s]++;
    end
  endfunction

  // one cycle: drive at negedge, check the load result at the next negedge
  task automatic op(input int s, input bit mm, input bit we, input bit pg,
                    input logic [11:0] off, input bit trg, input string req);
    bit e, rv;
    logic [63:0] rd;
    model(s, mm, we, pg, off, trg, 1, e, rd, rv);
    mm_req = mm; mm_we = we; mm_pg = pg; mm_src = SW'(s); mm_off = off;
    trig = '0; trig[s] = trg;
    @(negedge clk);
    mm_req = 0; trig = '0;
    check(rvalid == rv, req, "rvalid", rvalid, rv);
    if (rv) check(rdata == rd, req, "rdata", rdata, rd);
  endtask

  task automatic get(input int s, input string req);
    op(s, 1, 0, 0, 12'h800, 0, req);
  endtask

  // ready driver and notification counter
  always @(negedge clk) begin
    nready = hold ? 1'b0 : (drain ? 1'b1 : (($urandom % 4) != 0));
    if (nvalid && nready) got_cnt[nsrc]++;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      check(0, "WDOG", "watchdog expired", cyc, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    for (int s = 0; s < N; s++) begin pq_m[s] = 2'b00; exp_cnt[s] = 0; got_cnt[s] = 0; end
    repeat (3) @(negedge clk);
    check(nvalid == 0, "R1", "valid after reset", nvalid, 0);
    check(rvalid == 0, "R1", "rvalid after reset", rvalid, 0);
    rst_n = 1'b1;
    @(negedge clk);
    for (int s = 0; s < N; s++) get(s, "R1");

    // R11: hold ready low, trigger 0..5 in order
    hold = 1;
    for (int s = 0; s < 6; s++) op(s, 0, 0, 0, 12'h000, 1, "R2");
    repeat (3) @(negedge clk);
    check(nvalid == 1, "R11", "valid held", nvalid, 1);
    check(nsrc == 0, "R11", "first source", nsrc, 0);
    repeat (4) @(negedge clk);
    check(nvalid == 1 && nsrc == 0, "R11", "stable under stall", nsrc, 0);
    hold = 0; drain = 1;
    repeat (30) @(negedge clk);
    drain = 0;
    for (int s = 0; s < 6; s++) check(got_cnt[s] == 1, "R2", "one notification", got_cnt[s], 1);
    check(got_cnt[6] == 0, "R2", "untriggered source silent", got_cnt[6], 0);

    // directed corners on source 2 (state 10 now)
    op(2, 0, 0, 0, 12'h000, 1, "R3"); get(2, "R3");
    op(2, 1, 0, 0, 12'hD00, 0, "R6"); op(2, 0, 0, 0, 12'h000, 1, "R4"); get(2, "R4");
    op(2, 1, 0, 0, 12'hC00, 1, "R10"); get(2, "R10");
    op(2, 1, 0, 0, 12'hD00, 1, "R10"); get(2, "R10");
    op(2, 1, 0, 0, 12'hF00, 0, "R6");
    drain = 1; repeat (10) @(negedge clk); drain = 0;
    op(2, 1, 0, 0, 12'h000, 1, "R10"); get(2, "R10");
    drain = 1; repeat (10) @(negedge clk); drain = 0;
    op(2, 1, 0, 0, 12'h000, 0, "R7"); get(2, "R7");
    op(3, 1, 0, 0, 12'hF00, 0, "R6");
    drain = 1; repeat (10) @(negedge clk); drain = 0;
    op(3, 1, 1, 0, 12'h400, 0, "R8"); get(3, "R8");
    op(4, 1, 0, 0, 12'hC00, 0, "R6");
    op(4, 1, 1, 1, 12'h123, 0, "R9"); get(4, "R9");
    op(5, 1, 0, 0, 12'h300, 0, "R12"); op(5, 1, 1, 0, 12'hC00, 0, "R12");
    op(5, 1, 0, 1, 12'h800, 0, "R12"); get(5, "R12");

    // random phase
    for (int i = 0; i < 3000; i++) begin
      int s, k;
      bit mm, we, pg, trg, e, rv;
      logic [11:0] off;
      logic [63:0] rd;
      logic [11:0] offs [8] = '{12'h000, 12'h800, 12'hC00, 12'hD00,
                                12'hE00, 12'hF00, 12'h400, 12'h300};
      s = $urandom % N; k = $urandom % 8;
      mm = ($urandom % 4) != 0; pg = ($urandom % 8) == 0;
      we = (k == 6) || (k == 7 && ($urandom % 2)) || (pg && ($urandom % 2));
      off = offs[k] | 12'($urandom % 256);
      trg = ($urandom % 3) == 0;
      model(s, mm, we, pg, off, trg, 0, e, rd, rv);
      if (e && (exp_cnt[s] != got_cnt[s])) begin
        mm = 1; we = 0; pg = 0; off = 12'h800; trg = 0;
      end
      op(s, mm, we, pg, off, trg, "R10");
    end

    drain = 1;
    repeat (60) @(negedge clk);
    for (int s = 0; s < N; s++)
      check(got_cnt[s] == exp_cnt[s], "R11", "notification count", got_cnt[s], exp_cnt[s]);
    check(nvalid == 0, "R11", "drained", nvalid, 0);
    for (int s = 0; s < N; s++) get(s, "R5");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule